// File: doc/BRIEF.md
# CPU Status Flag and Interrupt-Enable Unit

This unit keeps three single-bit status flags for a small 4-bit processor core. The first is a zero flag that follows every ordinary accumulator load. The second is a pointer-overflow flag shared by the three address register pairs. The third is a master interrupt enable. The core's decoder drives a one-cycle strobe into the unit for each relevant operation. Each flag is registered and shows its new value from the clock edge that samples the strobe.

The unit also gates interrupts. It combines the raw maskable requests with the enable flag to form one request line to the core's sequencer. The watchdog request passes the gate in every state. The enable flag appears on the data bus as a read-only 4-bit register at one fixed address.

Top module: `cpu_flag_unit`

## Requirements
- R1: When `acc_load` is high and `acc_xchg` is low, `zero_flag` takes the value 1 after the next rising edge if `acc_data` equals 0, and 0 otherwise.
- R2: When `acc_load` and `acc_xchg` are both high, the exchange leaves `zero_flag` at its previous value.
- R3: When any bit i of `ptr_inc` is high together with bit i of `ptr_carry`, `g_flag` is 1 after the next edge. Bit 0, bit 1 and bit 2 select the three pairs.
- R4: When some bit of `ptr_inc` is high and no selected pair carries, `g_flag` is 0 after the next edge. With `ptr_inc` at zero, `g_flag` holds its value.
- R5: While reset is asserted, `zero_flag`, `g_flag` and `mie_flag` are 0. Maskable requests therefore do not reach `irq_out`.
- R6: A read (`bus_rd`) at address 8'hFF returns `{3'b000, mie_flag}` on `bus_rdata` in the same cycle. Bits 3 to 1 are always 0. A read at any other address, or no read at all, gives 4'h0.
- R7: A bus write (`bus_wr`) never changes `mie_flag`, whatever its address or data.
- R8: `irq_enable` or `irq_return` sets `mie_flag` to 1 after the next edge. `irq_accept` or `irq_disable` clears it to 0. When a set and a clear arrive in the same cycle, the clear wins.
- R9: `irq_out` equals `wdt_req | (mie_flag & (|irq_req))` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_load | input | 1 | Accumulator is written this cycle |
| acc_xchg | input | 1 | The accumulator write is an exchange |
| acc_data | input | 4 | Value written to the accumulator |
| ptr_inc | input | 3 | One bit per register pair incremented this cycle |
| ptr_carry | input | 3 | Carry out of each pair's increment |
| irq_accept | input | 1 | Core accepts an interrupt |
| irq_return | input | 1 | Return from interrupt |
| irq_enable | input | 1 | Enable-interrupts operation |
| irq_disable | input | 1 | Disable-interrupts operation |
| irq_req | input | 6 | Raw maskable interrupt requests |
| wdt_req | input | 1 | Watchdog interrupt request, not maskable |
| bus_rd | input | 1 | Data-memory read strobe |
| bus_wr | input | 1 | Data-memory write strobe |
| bus_addr | input | 8 | Data-memory address |
| bus_wdata | input | 4 | Data-memory write data |
| bus_rdata | output | 4 | Read data from the enable register |
| zero_flag | output | 1 | Zero flag |
| g_flag | output | 1 | Pointer-pair overflow flag |
| mie_flag | output | 1 | Master interrupt enable |
| irq_out | output | 1 | Gated interrupt request to the core |

## Verification
Each flag is a single register that feeds a port directly. A wrong next value for a flag therefore shows on its output one edge after the strobe that caused it. Most scenarios check one cycle after a strobe and once more after an idle cycle, which catches both a wrong update and a failure to hold. An enable flag that is set when it should be clear shows up in two other places as well. It makes `irq_out` assert for maskable requests, and it changes `bus_rdata` bit 0 in the same cycle as the read. The exchange case, the no-carry increment case and the simultaneous set and clear case each get their own directed sequence. These are the places where a plausible design could differ from the requirements.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;

    localparam int ACC_W     = 4;
    localparam int PAIRS     = 3;
    localparam int REQS      = 6;
    localparam int BUS_AW    = 8;
    localparam int REG_W     = 4;

    typedef struct packed {
        logic zero;
        logic ovf;
        logic mie;
    } flags_t;

    typedef enum logic [1:0] {
        MIE_HOLD  = 2'd0,
        MIE_SET   = 2'd1,
        MIE_CLEAR = 2'd2
    } mie_op_e;

    function automatic mie_op_e mie_decide(input logic set_req, input logic clr_req);
        if (clr_req)      return MIE_CLEAR;
        else if (set_req) return MIE_SET;
        else              return MIE_HOLD;
    endfunction

endpackage

// File: rtl/fu_zero_track.sv
module fu_zero_track #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          xchg,
    input  logic [DW-1:0] data,
    output logic          zero
);
    typedef struct packed {
        logic zero;
    } zst_t;

    zst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load && !xchg) begin
            st_d.zero = (data == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign zero = st_q.zero;
endmodule

// File: rtl/fu_ovf_track.sv
module fu_ovf_track #(
    parameter int NP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] inc,
    input  logic [NP-1:0] carry,
    output logic          ovf
);
    typedef struct packed {
        logic ovf;
    } ost_t;

    ost_t st_d, st_q;
    logic [NP-1:0] pair_wrap;

    for (genvar p = 0; p < NP; p++) begin : g_pair
        assign pair_wrap[p] = inc[p] & carry[p];
    end

    always_comb begin
        st_d = st_q;
        if (|pair_wrap) begin
            st_d.ovf = 1'b1;
        end else if (|inc) begin
            st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf = st_q.ovf;
endmodule

// File: rtl/fu_irq_ctrl.sv
module fu_irq_ctrl
    import flag_unit_pkg::*;
#(
    parameter int                 NR       = 6,
    parameter int                 AW       = 8,
    parameter int                 RW       = 4,
    parameter logic [AW-1:0]      REG_ADDR = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          ret,
    input  logic          en,
    input  logic          dis,
    input  logic [NR-1:0] req,
    input  logic          wdt,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    output logic [RW-1:0] rdata,
    output logic          mie,
    output logic          irq
);
    localparam int PAD_W = RW - 1;

    typedef struct packed {
        logic mie;
    } ist_t;

    ist_t    st_d, st_q;
    mie_op_e op;
    logic    hit;

    always_comb begin
        st_d = st_q;
        op   = mie_decide(en | ret, accept | dis);
        unique case (op)
            MIE_SET:   st_d.mie = 1'b1;
            MIE_CLEAR: st_d.mie = 1'b0;
            default:   st_d.mie = st_q.mie;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit   = rd && (addr == REG_ADDR);
    assign rdata = hit ? {{PAD_W{1'b0}}, st_q.mie} : '0;
    assign mie   = st_q.mie;
    assign irq   = wdt | (st_q.mie & (|req));
endmodule

// File: rtl/cpu_flag_unit.sv
module cpu_flag_unit
    import flag_unit_pkg::*;
#(
    parameter int            DATA_W   = ACC_W,
    parameter int            NUM_PAIR = PAIRS,
    parameter int            NUM_REQ  = REQS,
    parameter int            ADDR_W   = BUS_AW,
    parameter int            RDW      = REG_W,
    parameter logic [ADDR_W-1:0] MIE_ADDR = 8'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_load,
    input  logic                acc_xchg,
    input  logic [DATA_W-1:0]   acc_data,
    input  logic [NUM_PAIR-1:0] ptr_inc,
    input  logic [NUM_PAIR-1:0] ptr_carry,
    input  logic                irq_accept,
    input  logic                irq_return,
    input  logic                irq_enable,
    input  logic                irq_disable,
    input  logic [NUM_REQ-1:0]  irq_req,
    input  logic                wdt_req,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [RDW-1:0]      bus_rdata,
    output logic                zero_flag,
    output logic                g_flag,
    output logic                mie_flag,
    output logic                irq_out
);
    flags_t flags;

    // The enable register is read-only: bus writes are deliberately dropped.
    logic unused_write_path;
    assign unused_write_path = ^{bus_wr, bus_wdata};

    fu_zero_track #(.DW(DATA_W)) u_zero (
        .clk  (clk),
        .rst_n(rst_n),
        .load (acc_load),
        .xchg (acc_xchg),
        .data (acc_data),
        .zero (flags.zero)
    );

    fu_ovf_track #(.NP(NUM_PAIR)) u_ovf (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (ptr_inc),
        .carry(ptr_carry),
        .ovf  (flags.ovf)
    );

    fu_irq_ctrl #(
        .NR      (NUM_REQ),
        .AW      (ADDR_W),
        .RW      (RDW),
        .REG_ADDR(MIE_ADDR)
    ) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .accept(irq_accept),
        .ret   (irq_return),
        .en    (irq_enable),
        .dis   (irq_disable),
        .req   (irq_req),
        .wdt   (wdt_req),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .rdata (bus_rdata),
        .mie   (flags.mie),
        .irq   (irq_out)
    );

    assign zero_flag = flags.zero;
    assign g_flag    = flags.ovf;
    assign mie_flag  = flags.mie;
endmodule

// File: rtl/fu_flag_checker.sv
module fu_flag_checker #(
    parameter int DATA_W   = 4,
    parameter int NUM_PAIR = 3,
    parameter int NUM_REQ  = 6,
    parameter int ADDR_W   = 8,
    parameter int RDW      = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_load,
    input logic                acc_xchg,
    input logic [DATA_W-1:0]   acc_data,
    input logic [NUM_PAIR-1:0] ptr_inc,
    input logic [NUM_PAIR-1:0] ptr_carry,
    input logic                irq_accept,
    input logic                irq_return,
    input logic                irq_enable,
    input logic                irq_disable,
    input logic [NUM_REQ-1:0]  irq_req,
    input logic                wdt_req,
    input logic                bus_wr,
    input logic [RDW-1:0]      bus_rdata,
    input logic                zero_flag,
    input logic                g_flag,
    input logic                mie_flag,
    input logic                irq_out
);
    AST_ZERO_ON_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_load && !acc_xchg && acc_data == '0) |=> zero_flag); // R1
    AST_ZERO_OFF_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_load && !acc_xchg && acc_data != '0) |=> !zero_flag); // R1
    AST_XCHG_KEEPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_load && acc_xchg) |=> $stable(zero_flag)); // R2
    AST_WRAP_SETS_G: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ptr_inc & ptr_carry)) |=> g_flag); // R3
    AST_PLAIN_INC_CLEARS_G: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ptr_inc) && !(|(ptr_inc & ptr_carry))) |=> !g_flag); // R4
    AST_IDLE_KEEPS_G: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc == '0) |=> $stable(g_flag)); // R4
    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[RDW-1:1] == '0); // R6
    AST_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !irq_accept && !irq_return && !irq_enable && !irq_disable)
        |=> $stable(mie_flag)); // R7
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_accept || irq_disable) |=> !mie_flag); // R8
    AST_SET_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_enable || irq_return) && !irq_accept && !irq_disable) |=> mie_flag); // R8
    AST_WDT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req |-> irq_out); // R9
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_req && !mie_flag) |-> !irq_out); // R9
    AST_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_req && irq_req == '0) |-> !irq_out); // R9
endmodule

bind cpu_flag_unit fu_flag_checker #(
    .DATA_W  (DATA_W),
    .NUM_PAIR(NUM_PAIR),
    .NUM_REQ (NUM_REQ),
    .ADDR_W  (ADDR_W),
    .RDW     (RDW)
) chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_load   (acc_load),
    .acc_xchg   (acc_xchg),
    .acc_data   (acc_data),
    .ptr_inc    (ptr_inc),
    .ptr_carry  (ptr_carry),
    .irq_accept (irq_accept),
    .irq_return (irq_return),
    .irq_enable (irq_enable),
    .irq_disable(irq_disable),
    .irq_req    (irq_req),
    .wdt_req    (wdt_req),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .zero_flag  (zero_flag),
    .g_flag     (g_flag),
    .mie_flag   (mie_flag),
    .irq_out    (irq_out)
);

// File: tb/cpu_flag_unit_test.sv
`timescale 1ns/1ps
module cpu_flag_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_load, acc_xchg;
    logic [3:0] acc_data;
    logic [2:0] ptr_inc, ptr_carry;
    logic       irq_accept, irq_return, irq_enable, irq_disable;
    logic [5:0] irq_req;
    logic       wdt_req, bus_rd, bus_wr;
    logic [7:0] bus_addr;
    logic [3:0] bus_wdata, bus_rdata;
    logic       zero_flag, g_flag, mie_flag, irq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    cpu_flag_unit uut (
        .clk(clk), .rst_n(rst_n),
        .acc_load(acc_load), .acc_xchg(acc_xchg), .acc_data(acc_data),
        .ptr_inc(ptr_inc), .ptr_carry(ptr_carry),
        .irq_accept(irq_accept), .irq_return(irq_return),
        .irq_enable(irq_enable), .irq_disable(irq_disable),
        .irq_req(irq_req), .wdt_req(wdt_req),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .zero_flag(zero_flag), .g_flag(g_flag), .mie_flag(mie_flag),
        .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        acc_load = 0; acc_xchg = 0; acc_data = 0;
        ptr_inc = 0; ptr_carry = 0;
        irq_accept = 0; irq_return = 0; irq_enable = 0; irq_disable = 0;
        irq_req = 0; wdt_req = 0;
        bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    endtask

    // Apply current inputs for one edge, then clear strobes; sample after the edge.
    task automatic step();
        @(posedge clk);
        #1;
        acc_load = 0; acc_xchg = 0; ptr_inc = 0; ptr_carry = 0;
        irq_accept = 0; irq_return = 0; irq_enable = 0; irq_disable = 0;
        bus_wr = 0;
    endtask

    task automatic test_reset();
        irq_req = 6'h3F;
        #1;
        check("R5 zero", {3'b0, zero_flag}, 4'h0);
        check("R5 g", {3'b0, g_flag}, 4'h0);
        check("R5 mie", {3'b0, mie_flag}, 4'h0);
        check("R5 irq_out masked", {3'b0, irq_out}, 4'h0);
        irq_req = 0;
    endtask

    task automatic test_zero();
        acc_load = 1; acc_data = 4'h0; step();
        check("R1 load 0", {3'b0, zero_flag}, 4'h1);
        acc_load = 1; acc_data = 4'h5; step();
        check("R1 load 5", {3'b0, zero_flag}, 4'h0);
        acc_load = 1; acc_data = 4'h0; step();
        check("R1 load 0 again", {3'b0, zero_flag}, 4'h1);
        acc_load = 1; acc_xchg = 1; acc_data = 4'h7; step();
        check("R2 xchg 7 keeps 1", {3'b0, zero_flag}, 4'h1);
        acc_load = 1; acc_data = 4'h9; step();
        check("R1 load 9", {3'b0, zero_flag}, 4'h0);
        acc_load = 1; acc_xchg = 1; acc_data = 4'h0; step();
        check("R2 xchg 0 keeps 0", {3'b0, zero_flag}, 4'h0);
        step();
        check("R1 idle hold", {3'b0, zero_flag}, 4'h0);
    endtask

    task automatic test_ovf();
        ptr_inc = 3'b001; step();
        check("R4 inc pair0 no carry", {3'b0, g_flag}, 4'h0);
        ptr_inc = 3'b010; ptr_carry = 3'b010; step();
        check("R3 pair1 carry", {3'b0, g_flag}, 4'h1);
        ptr_carry = 3'b111; step();
        check("R4 idle hold, stray carry", {3'b0, g_flag}, 4'h1);
        ptr_inc = 3'b100; step();
        check("R4 pair2 no carry clears", {3'b0, g_flag}, 4'h0);
        ptr_inc = 3'b100; ptr_carry = 3'b100; step();
        check("R3 pair2 carry", {3'b0, g_flag}, 4'h1);
        ptr_inc = 3'b001; ptr_carry = 3'b001; step();
        check("R3 pair0 carry", {3'b0, g_flag}, 4'h1);
        ptr_inc = 3'b001; ptr_carry = 3'b010; step();
        check("R4 pair0 no carry (unselected carry)", {3'b0, g_flag}, 4'h0);
    endtask

    task automatic test_mie();
        irq_enable = 1; step();
        check("R8 enable", {3'b0, mie_flag}, 4'h1);
        irq_accept = 1; step();
        check("R8 accept clears", {3'b0, mie_flag}, 4'h0);
        irq_return = 1; step();
        check("R8 return sets", {3'b0, mie_flag}, 4'h1);
        irq_disable = 1; step();
        check("R8 disable clears", {3'b0, mie_flag}, 4'h0);
        irq_enable = 1; irq_accept = 1; step();
        check("R8 accept beats enable", {3'b0, mie_flag}, 4'h0);
        irq_return = 1; irq_disable = 1; step();
        check("R8 disable beats return", {3'b0, mie_flag}, 4'h0);
        irq_return = 1; step();
        step();
        check("R8 hold after set", {3'b0, mie_flag}, 4'h1);
    endtask

    task automatic test_read();
        // mie is 1 here
        bus_rd = 1; bus_addr = 8'hFF; #1;
        check("R6 read FF with mie=1", bus_rdata, 4'h1);
        bus_addr = 8'hFE; #1;
        check("R6 read other address", bus_rdata, 4'h0);
        bus_rd = 0; bus_addr = 8'hFF; #1;
        check("R6 no read strobe", bus_rdata, 4'h0);
        irq_disable = 1; step();
        bus_rd = 1; #1;
        check("R6 read FF with mie=0", bus_rdata, 4'h0);
        bus_rd = 0;
    endtask

    task automatic test_write();
        // mie is 0 here
        bus_wr = 1; bus_addr = 8'hFF; bus_wdata = 4'hF; step();
        check("R7 write F keeps mie=0", {3'b0, mie_flag}, 4'h0);
        bus_rd = 1; #1;
        check("R7 readback after write", bus_rdata, 4'h0);
        bus_rd = 0;
        irq_enable = 1; step();
        bus_wr = 1; bus_addr = 8'hFF; bus_wdata = 4'h0; step();
        check("R7 write 0 keeps mie=1", {3'b0, mie_flag}, 4'h1);
        bus_wr = 1; bus_addr = 8'h10; bus_wdata = 4'h0; step();
        check("R7 write elsewhere keeps mie=1", {3'b0, mie_flag}, 4'h1);
    endtask

    task automatic test_gate();
        irq_disable = 1; step();
        irq_req = 6'b100000; wdt_req = 0; #1;
        check("R9 masked request", {3'b0, irq_out}, 4'h0);
        wdt_req = 1; #1;
        check("R9 watchdog passes mask", {3'b0, irq_out}, 4'h1);
        wdt_req = 0; irq_enable = 1; step();
        check("R9 enabled request", {3'b0, irq_out}, 4'h1);
        irq_req = 0; #1;
        check("R9 no request", {3'b0, irq_out}, 4'h0);
        irq_req = 6'b000001; #1;
        check("R9 low request bit", {3'b0, irq_out}, 4'h1);
        irq_req = 0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        #12;
        test_reset();
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        test_zero();
        test_ovf();
        test_mie();
        test_read();
        test_write();
        test_gate();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule